// File: doc/BRIEF.md
# Edge-Triggered Request Router with Pattern-Gated Outputs

This block preprocesses interrupt requests before they reach an interrupt controller. There is a shared pool of request lines, all synchronous to the block clock. Each line is re-timed through a two-stage synchronizer, and its previous value is kept, so that rising and falling edges are known for every line. Each of four channels picks one line from the pool and turns the enabled edge types on that line into a trigger. A trigger also raises a sticky per-channel event flag.

A routing field in every channel selects which of four output gates receive that channel's trigger. Each gate forms a pattern bit: the AND of the event flags named by its mask. The gate then lets routed triggers through as a single-cycle interrupt pulse according to its mode. The mode is one of never, always, only while the pattern holds, or only while it does not hold. The pattern bits are also driven out as status.

Configuration is written through a simple write port. Channel registers sit at addresses 0 to 3, a flag clear register at address 4, and gate registers at addresses 8 to 11.

Top module: `evt_route_top`

## Requirements
- R1: A level change on a request line can cause a trigger no earlier than the third rising clock edge after the change is presented. A configured trigger registers its flag and its interrupt pulse on that third edge.
- R2: A channel register (address c, data bits [7:0]) holds the source select in bits [1:0], a rise enable in bit 2 and a fall enable in bit 3. With both enables set, any change of the selected line triggers. With neither set, no trigger occurs.
- R3: Changing a channel's source select does not by itself create a trigger, even when the old and new lines differ in level.
- R4: A trigger sets the channel's event flag, which stays set until a write to address 4 with a 1 in data bit c clears flag c. Zeros in that write leave flags untouched.
- R5: When a clear and a trigger for the same flag land in the same cycle, the flag ends up set.
- R6: Bit 4+g of a channel register routes that channel's trigger to gate g. A channel may feed any number of gates.
- R7: pat_out[g] is the AND of the event flags whose bits are set in the mask, bits [3:0] of the gate register at address 8+g. An empty mask gives 1.
- R8: Gate mode, bits [5:4] of the gate register, behaves as follows: 0 passes nothing, 1 passes every routed trigger, 2 passes only while the pattern is 1, and 3 passes only while the pattern is 0. The pattern is taken from the flags as they stood before the triggering cycle's update.
- R9: irq_out[g] is high for exactly one cycle per cycle in which at least one routed trigger passes. Simultaneous triggers on one gate give one pulse.
- R10: After reset all flags, outputs and channel registers are zero, and gate registers hold mode 0 with an all-ones mask, so pat_out reads 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 4 | Pool of request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| irq_out | output | 4 | Single-cycle interrupt pulses, one per gate |
| pat_out | output | 4 | Pattern status bit per gate |

## Verification
A flag clear written through the configuration port and an edge-driven flag set on the same channel can meet in one cycle. One directed sequence places a clear write on exactly the cycle in which a synchronized rising edge reaches the channel. The set must win, which is judged through pat_out of a gate whose mask selects only that flag. The same collision, along with triggers arriving while a gate's mask or mode is being rewritten, is also reached by seeded random traffic. In that traffic every cycle's irq_out and pat_out are compared against a bench model built from the requirements.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
  parameter int unsigned NCH       = 4;
  parameter int unsigned NSRC      = 4;
  parameter int unsigned NGATE     = 4;
  parameter int unsigned ADDR_W    = 4;
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned SEL_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
  parameter int unsigned CLR_ADDR  = NCH;
  parameter int unsigned GATE_BASE = 8;

  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_ON    = 2'd1,
    GATE_MATCH = 2'd2,
    GATE_MISS  = 2'd3
  } gate_mode_t;

  typedef struct packed {
    logic [NGATE-1:0] route;
    logic             fall_en;
    logic             rise_en;
    logic [SEL_W-1:0] src;
  } chan_cfg_t;

  typedef struct packed {
    gate_mode_t     mode;
    logic [NCH-1:0] mask;
  } gate_cfg_t;

  localparam int unsigned CH_W = $bits(chan_cfg_t);
  localparam int unsigned GT_W = $bits(gate_cfg_t);
endpackage

// File: rtl/evt_cfg.sv
module evt_cfg
  import evt_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output chan_cfg_t         chan_cfg [NCH],
  output gate_cfg_t         gate_cfg [NGATE],
  output logic [NCH-1:0]    clr_mask
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic      ld;
    chan_cfg_t nxt;
    always_comb begin
      ld  = wr_en && (wr_addr == ADDR_W'(c));
      nxt = chan_cfg_t'(wr_data[CH_W-1:0]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  chan_cfg[c] <= '0;
      else if (ld) chan_cfg[c] <= nxt;
    end
  end

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    logic      ld;
    gate_cfg_t nxt;
    always_comb begin
      ld  = wr_en && (wr_addr == ADDR_W'(GATE_BASE + g));
      nxt = gate_cfg_t'(wr_data[GT_W-1:0]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gate_cfg[g] <= '{mode: GATE_OFF, mask: '1};
      else if (ld) gate_cfg[g] <= nxt;
    end
  end

  always_comb begin
    clr_mask = '0;
    if (wr_en && (wr_addr == ADDR_W'(CLR_ADDR))) clr_mask = wr_data[NCH-1:0];
  end

endmodule

// File: rtl/evt_sync.sv
module evt_sync
  import evt_route_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] rise,
  output logic [NSRC-1:0] fall
);

  logic [NSRC-1:0] stg1_q, stg2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      prev_q <= '0;
    end else begin
      stg1_q <= req;
      stg2_q <= stg1_q;
      prev_q <= stg2_q;
    end
  end

  always_comb begin
    rise = stg2_q & ~prev_q;
    fall = ~stg2_q & prev_q;
  end

  // R1: an edge seen now reflects the line level two samples back
  a_r1_rise_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |-> ((rise & $past(req, 2)) == rise));
  a_r1_fall_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != '0) |-> ((fall & ~$past(req, 2)) == fall));

endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_route_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] fall,
  input  chan_cfg_t       cfg,
  input  logic            clr,
  output logic            trig,
  output logic            flag
);

  logic flag_d;

  always_comb begin
    trig   = (cfg.rise_en & rise[cfg.src]) | (cfg.fall_en & fall[cfg.src]);
    flag_d = (flag & ~clr) | trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R5: a trigger always leaves the flag set, clear or not
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> flag);
  // R4: flags are sticky without a clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !trig) |=> !flag);

endmodule

// File: rtl/evt_gate.sv
module evt_gate
  import evt_route_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_vec,
  input  logic [NCH-1:0] flags,
  input  gate_cfg_t      cfg,
  output logic           irq,
  output logic           pat
);

  logic pass, irq_d;

  always_comb begin
    pat = &(flags | ~cfg.mask);
    unique case (cfg.mode)
      GATE_OFF:   pass = 1'b0;
      GATE_ON:    pass = 1'b1;
      GATE_MATCH: pass = pat;
      GATE_MISS:  pass = ~pat;
      default:    pass = 1'b0;
    endcase
    irq_d = (|hit_vec) & pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R8: gate modes block as specified
  a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == GATE_OFF) |=> !irq);
  a_r8_match_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == GATE_MATCH && !pat) |=> !irq);
  a_r8_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == GATE_MISS && pat) |=> !irq);
  // R9: no pulse without a routed trigger
  a_r9_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |=> !irq);

endmodule

// File: rtl/evt_route_top.sv
module evt_route_top
  import evt_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [NGATE-1:0]  irq_out,
  output logic [NGATE-1:0]  pat_out
);

  logic [1:0]      rst_pipe;
  logic            rst_n_sync;
  chan_cfg_t       chan_cfg [NCH];
  gate_cfg_t       gate_cfg [NGATE];
  logic [NCH-1:0]  clr_mask;
  logic [NSRC-1:0] rise, fall;
  logic [NCH-1:0]  trig, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  evt_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .chan_cfg (chan_cfg),
    .gate_cfg (gate_cfg),
    .clr_mask (clr_mask)
  );

  evt_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .req   (req_in),
    .rise  (rise),
    .fall  (fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    evt_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .rise  (rise),
      .fall  (fall),
      .cfg   (chan_cfg[c]),
      .clr   (clr_mask[c]),
      .trig  (trig[c]),
      .flag  (flags[c])
    );
  end

  for (genvar g = 0; g < NGATE; g++) begin : g_gt
    logic [NCH-1:0] hit;
    always_comb begin
      for (int c = 0; c < NCH; c++) hit[c] = trig[c] & chan_cfg[c].route[g];
    end
    evt_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .hit_vec (hit),
      .flags   (flags),
      .cfg     (gate_cfg[g]),
      .irq     (irq_out[g]),
      .pat     (pat_out[g])
    );
  end

endmodule

// File: tb/evt_route_top_test.sv
`timescale 1ns/100ps
module evt_route_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_in;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [3:0] irq_out, pat_out;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  evt_route_top uut (
    .clk (clk), .rst_n (rst_n), .req_in (req_in),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .irq_out (irq_out), .pat_out (pat_out)
  );

  // Reference model built from the requirements
  logic [3:0] m_s1, m_s2, m_pv, m_flag, m_irq;
  logic [7:0] m_cc [4];
  logic [5:0] m_gc [4];
  logic       mr1, mr2;

  function automatic logic pat_of(logic [3:0] fl, logic [3:0] mk);
    return &(fl | ~mk);
  endfunction

  function automatic logic pass_of(logic [1:0] md, logic p);
    case (md)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return p;
      default: return ~p;
    endcase
  endfunction

  function automatic logic [3:0] exp_pat();
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = pat_of(m_flag, m_gc[g][3:0]);
    return r;
  endfunction

  task automatic m_reset();
    m_s1 = '0; m_s2 = '0; m_pv = '0; m_flag = '0; m_irq = '0;
    for (int i = 0; i < 4; i++) begin m_cc[i] = '0; m_gc[i] = 6'b00_1111; end
  endtask

  task automatic m_step();
    logic [3:0] rs, fs, t, clr;
    logic       hit;
    rs = m_s2 & ~m_pv;
    fs = ~m_s2 & m_pv;
    for (int c = 0; c < 4; c++)
      t[c] = (m_cc[c][2] & rs[m_cc[c][1:0]]) | (m_cc[c][3] & fs[m_cc[c][1:0]]);
    for (int g = 0; g < 4; g++) begin
      hit = 1'b0;
      for (int c = 0; c < 4; c++) hit = hit | (t[c] & m_cc[c][4+g]);
      m_irq[g] = hit & pass_of(m_gc[g][5:4], pat_of(m_flag, m_gc[g][3:0]));
    end
    clr    = (cfg_we && cfg_addr == 4'd4) ? cfg_wdata[3:0] : 4'd0;
    m_flag = (m_flag & ~clr) | t;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = req_in;
    if (cfg_we) begin
      if (cfg_addr < 4'd4) m_cc[cfg_addr[1:0]] = cfg_wdata;
      else if (cfg_addr >= 4'd8 && cfg_addr <= 4'd11) m_gc[cfg_addr[1:0]] = cfg_wdata[5:0];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 1'b0; mr2 = 1'b0; m_reset();
    end else begin
      if (!mr2) m_reset(); else m_step();
      mr2 = mr1; mr1 = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(irq_out === m_irq, "R6 R8 R9 irq_out vs model", int'(irq_out), int'(m_irq));
    chk(pat_out === exp_pat(), "R7 pat_out vs model", int'(pat_out), int'(exp_pat()));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_in = 4'b0010; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) step();
    // R10: reset state
    chk(irq_out == 4'd0, "R10 reset irq_out", int'(irq_out), 0);
    chk(pat_out == 4'd0, "R10 reset pat_out", int'(pat_out), 0);
    wr(4'd6, 8'hFF);  // R10: unmapped address
    chk(pat_out == 4'd0, "R10 unmapped write", int'(pat_out), 0);

    // R1, R2, R6, R9: ch0 line0 rising, routed to gate0 in always mode
    wr(4'd0, 8'h14);
    wr(4'd8, 8'h10);
    chk(pat_out[0] == 1'b1, "R7 empty mask reads 1", int'(pat_out[0]), 1);
    wr(4'd9, 8'h21);  // gate1: match on flag0 only
    req_in[0] = 1'b1;
    step(); chk(irq_out[0] == 1'b0, "R1 no pulse after 1 edge", int'(irq_out[0]), 0);
    step(); chk(irq_out[0] == 1'b0, "R1 no pulse after 2 edges", int'(irq_out[0]), 0);
    step(); chk(irq_out[0] == 1'b1, "R1 pulse on 3rd edge", int'(irq_out[0]), 1);
    step(); chk(irq_out[0] == 1'b0, "R9 pulse lasts one cycle", int'(irq_out[0]), 0);
    chk(pat_out[1] == 1'b1, "R4 flag0 set", int'(pat_out[1]), 1);

    // R4: clear, then falling edge ignored with rise only
    wr(4'd4, 8'h01);
    chk(pat_out[1] == 1'b0, "R4 flag0 cleared", int'(pat_out[1]), 0);
    req_in[0] = 1'b0;
    repeat (4) step();
    chk(pat_out[1] == 1'b0, "R2 fall ignored when rise only", int'(pat_out[1]), 0);
    chk(irq_out == 4'd0, "R2 no pulse on fall", int'(irq_out), 0);

    // R5: clear written on the cycle the edge arrives
    req_in[0] = 1'b1;
    step(); step();
    wr(4'd4, 8'h01);
    chk(pat_out[1] == 1'b1, "R5 set wins over clear", int'(pat_out[1]), 1);
    chk(irq_out[0] == 1'b1, "R5 pulse still issued", int'(irq_out[0]), 1);

    // R3: switch source from a low line to a high line
    req_in[0] = 1'b0;
    repeat (4) step();
    wr(4'd4, 8'h0F);
    wr(4'd0, 8'h15);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(irq_out == 4'd0 && pat_out[1] == 1'b0, "R3 no trigger on source switch",
          int'({pat_out, irq_out}), 0);
    end

    // Random traffic checked each cycle against the model (R2, R6, R7, R8, R9)
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 3 == 0) req_in = req_in ^ 4'(1 << ($urandom % 4));
      if ($urandom % 6 == 0) begin
        r = int'($urandom % 12);
        cfg_we    = 1'b1;
        cfg_addr  = (r < 5) ? 4'(r) : (r < 9) ? 4'(r + 3) : (r == 9) ? 4'd5 : (r == 10) ? 4'd7 : 4'd14;
        cfg_wdata = 8'($urandom);
      end else begin
        cfg_we = 1'b0;
      end
      step();
    end
    cfg_we = 1'b0;
    summary();
    $finish;
  end
endmodule